// File: doc/BRIEF.md
# Paravirtual Device Register Front-End

This block is the 32-bit control register slave of a paravirtual device that a guest driver reaches through plain memory-mapped loads and stores. It answers the fixed identification words, shows the 64-bit device feature set through a selectable 32-bit window, and collects the 64-bit set of features the driver accepts through a second window. It also holds the device status byte, and a driver write of zero to that byte resets the device.

Two event pulses come in from the device core: "a buffer was used" and "the configuration changed". Each one sets its own latched interrupt status bit, and the driver clears a bit by writing a one at the matching position of the acknowledge register. A single level interrupt output is high while any status bit is set. The configuration-change pulse, and any driver write to the small configuration scratch area, also advance a generation counter. The driver reads that counter before and after it reads the configuration, so it can tell whether the two reads saw the same configuration. A shared-memory region selector returns a base and a length for each region that exists and all-ones for each one that does not.

Accesses are aligned 32-bit words. The bus has an address, write data, a write strobe and a read strobe. Read data is registered: it appears in the cycle after the read strobe and holds its value until the next read.

Top module: `pvdev_regfront`

## Requirements
- R1: Reads of 0x000, 0x004, 0x008 and 0x00C return 0x74726976, 0x00000002, the DEV_ID parameter and the VENDOR_ID parameter.
- R2: A read of 0x010 returns bits sel*32 to sel*32+31 of `dev_feat_i`, where sel is the last value written to 0x014 (0 or 1). Any other sel reads zero.
- R3: A write to 0x020 stores the written word into bits sel*32 to sel*32+31 of `drv_feat_o`, where sel is the last value written to 0x024. For a sel of 2 or more the write has no effect. `drv_feat_o` changes only on such a write or on a device reset.
- R4: Interrupt status at 0x060 has bit 0 for a used buffer and bit 1 for a configuration change, and bits 31:2 read zero. A pulse on `used_evt_i` or `cfg_chg_i` sets its bit from the next cycle. Writing 0x064 with bit n at one clears bit n, and a zero bit leaves its status bit alone. An event and an acknowledge of the same bit in one cycle leave the bit set.
- R5: `irq_o` is high exactly while any interrupt status bit is set.
- R6: A write to 0x070 whose value is not zero stores bits 7:0 as the status byte. The byte is shown on `status_o` and reads back at 0x070.
- R7: A write of zero to 0x070 clears the status byte, the interrupt status, the driver feature words, both feature selectors and the shared-memory selector. Events that arrive in the same cycle are dropped. `dev_reset_o` is high for the one cycle after the write, so the device core can clear its queue-ready bits.
- R8: The generation counter at 0x0FC increases by exactly one in each cycle that has a `cfg_chg_i` pulse, a configuration scratch write, or both. Otherwise it keeps its value. A device reset does not clear it.
- R9: The configuration scratch area has CFG_WORDS read/write words at 0x100 + 4*k, and all of them are zero after reset.
- R10: The shared-memory selector at 0x0AC is read/write. For a selected region k below NUM_SHM, 0x0B0/0x0B4 read the low/high halves of SHM_LEN and 0x0B8/0x0BC read the low/high halves of SHM_BASE + k*SHM_LEN. For any other selector value all four read 0xFFFFFFFF.
- R11: Reads of write-only offsets (0x014, 0x020, 0x024, 0x064), unmapped offsets and misaligned addresses return zero. Writes to read-only, unmapped or misaligned addresses change no state.
- R12: `bus_rdata` is loaded only in the cycle after `bus_rd` is high, and it holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| dev_feat_i | input | FEAT_WORDS*32 | Feature set offered by the device core |
| used_evt_i | input | 1 | Used-buffer event pulse |
| cfg_chg_i | input | 1 | Configuration-change event pulse |
| irq_o | output | 1 | Level interrupt request |
| status_o | output | 8 | Current device status byte |
| drv_feat_o | output | FEAT_WORDS*32 | Feature set accepted by the driver |
| dev_reset_o | output | 1 | One-cycle device reset request |

## Verification
Assertions are checked on every cycle. They cover these cases:
- A zero write to status is followed by a quiet interrupt line, a cleared status byte and cleared driver features, and it is the only cause of the reset pulse.
- A used-buffer event raises the interrupt, and the interrupt cannot drop without a bus write.
- Each configuration change moves the generation counter by exactly one, and the counter holds when nothing could change it.
- Read data, status and driver features hold when no bus access could change them.

Only the bench scenarios can show the rest, because each of these behaviours depends on what was written or selected earlier:
- The values returned through the feature windows at each selector value.
- Acknowledge of one bit leaving the other bit set.
- An event and an acknowledge of the same bit in one cycle.
- The shared-memory sentinels for an absent region.
- Zero reads from write-only, unmapped and misaligned addresses.
- Ignored writes to read-only words.

// File: rtl/pvdev_pkg.sv
`timescale 1ns/1ps
package pvdev_pkg;
  localparam logic [31:0] PV_MAGIC   = 32'h7472_6976;
  localparam logic [31:0] PV_VERSION = 32'h0000_0002;

  localparam int IRQ_W     = 2;
  localparam int IRQ_USED  = 0;
  localparam int IRQ_CFG   = 1;

  localparam logic [11:0] OFF_MAGIC     = 12'h000;
  localparam logic [11:0] OFF_VERSION   = 12'h004;
  localparam logic [11:0] OFF_DEVID     = 12'h008;
  localparam logic [11:0] OFF_VENDOR    = 12'h00C;
  localparam logic [11:0] OFF_DFEAT     = 12'h010;
  localparam logic [11:0] OFF_DFSEL     = 12'h014;
  localparam logic [11:0] OFF_GFEAT     = 12'h020;
  localparam logic [11:0] OFF_GFSEL     = 12'h024;
  localparam logic [11:0] OFF_ISTAT     = 12'h060;
  localparam logic [11:0] OFF_IACK      = 12'h064;
  localparam logic [11:0] OFF_STATUS    = 12'h070;
  localparam logic [11:0] OFF_SHMSEL    = 12'h0AC;
  localparam logic [11:0] OFF_SHMLEN_L  = 12'h0B0;
  localparam logic [11:0] OFF_SHMLEN_H  = 12'h0B4;
  localparam logic [11:0] OFF_SHMBASE_L = 12'h0B8;
  localparam logic [11:0] OFF_SHMBASE_H = 12'h0BC;
  localparam logic [11:0] OFF_GEN       = 12'h0FC;
  localparam logic [11:0] OFF_CFG       = 12'h100;

  typedef struct packed {
    logic [63:0] base;
    logic [63:0] len;
  } shm_desc_t;
endpackage

// File: rtl/pvdev_irqstat.sv
`timescale 1ns/1ps
module pvdev_irqstat
  import pvdev_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [IRQ_W-1:0] evt,
  input  logic             ack_we,
  input  logic [IRQ_W-1:0] ack,
  output logic [IRQ_W-1:0] stat
);
  logic [IRQ_W-1:0] stat_q, stat_nxt, ack_mask;
  logic             stat_en;

  always_comb begin
    ack_mask = ack_we ? ack : '0;
    stat_en  = clr | ack_we | (|evt);
    if (clr) stat_nxt = '0;
    else     stat_nxt = (stat_q & ~ack_mask) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_nxt;
  end

  assign stat = stat_q;
endmodule

// File: rtl/pvdev_featwin.sv
`timescale 1ns/1ps
module pvdev_featwin #(
  parameter int NW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NW*32-1:0] dev_feat,
  input  logic             dsel_we,
  input  logic             gsel_we,
  input  logic             gfeat_we,
  input  logic [31:0]      wdata,
  output logic [31:0]      dev_word,
  output logic [NW*32-1:0] drv_feat
);
  logic [31:0] dsel_q, dsel_nxt, gsel_q, gsel_nxt;
  logic        dsel_en, gsel_en;

  always_comb begin
    dsel_en  = clr | dsel_we;
    gsel_en  = clr | gsel_we;
    dsel_nxt = clr ? '0 : wdata;
    gsel_nxt = clr ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsel_q <= '0;
      gsel_q <= '0;
    end else begin
      if (dsel_en) dsel_q <= dsel_nxt;
      if (gsel_en) gsel_q <= gsel_nxt;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_drv_word
    logic [31:0] word_q, word_nxt;
    logic        word_en;
    always_comb begin
      word_en  = clr | (gfeat_we & (gsel_q == 32'(g)));
      word_nxt = clr ? '0 : wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_nxt;
    end
    assign drv_feat[g*32 +: 32] = word_q;
  end

  always_comb begin
    dev_word = '0;
    for (int i = 0; i < NW; i++) begin
      if (dsel_q == 32'(i)) dev_word = dev_feat[i*32 +: 32];
    end
  end
endmodule

// File: rtl/pvdev_cfgspace.sv
`timescale 1ns/1ps
module pvdev_cfgspace
  import pvdev_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int GEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      addr,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  input  logic             chg,
  output logic             hit,
  output logic [31:0]      rword,
  output logic [GEN_W-1:0] gen
);
  logic [31:0]      cfg_q [WORDS];
  logic [GEN_W-1:0] gen_q, gen_nxt;
  logic             gen_en;

  always_comb begin
    hit   = 1'b0;
    rword = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (addr == OFF_CFG + 12'(4*i)) begin
        hit   = 1'b1;
        rword = cfg_q[i];
      end
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_cfg_word
    logic word_en;
    assign word_en = wr_en & (addr == OFF_CFG + 12'(4*g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q[g] <= '0;
      else if (word_en) cfg_q[g] <= wdata;
    end
  end

  always_comb begin
    gen_en  = chg | (wr_en & hit);
    gen_nxt = gen_q + GEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gen_q <= '0;
    else if (gen_en) gen_q <= gen_nxt;
  end

  assign gen = gen_q;
endmodule

// File: rtl/pvdev_regfront.sv
`timescale 1ns/1ps
module pvdev_regfront
  import pvdev_pkg::*;
#(
  parameter int          ADDR_W     = 9,
  parameter logic [31:0] DEV_ID     = 32'd1,
  parameter logic [31:0] VENDOR_ID  = 32'h0000_5A17,
  parameter int          FEAT_WORDS = 2,
  parameter int          CFG_WORDS  = 4,
  parameter int          GEN_W      = 32,
  parameter int          NUM_SHM    = 1,
  parameter logic [63:0] SHM_BASE   = 64'h0000_0040_0000_0000,
  parameter logic [63:0] SHM_LEN    = 64'h0000_0000_0010_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [31:0]             bus_rdata,
  input  logic [FEAT_WORDS*32-1:0] dev_feat_i,
  input  logic                    used_evt_i,
  input  logic                    cfg_chg_i,
  output logic                    irq_o,
  output logic [7:0]              status_o,
  output logic [FEAT_WORDS*32-1:0] drv_feat_o,
  output logic                    dev_reset_o
);
  localparam int FEAT_W = FEAT_WORDS * 32;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  // address decode
  logic [11:0] a12;
  logic w_dfsel, w_gfeat, w_gfsel, w_iack, w_status, w_shmsel, zero_wr;
  assign a12      = 12'(bus_addr);
  assign w_dfsel  = bus_wr & (a12 == OFF_DFSEL);
  assign w_gfeat  = bus_wr & (a12 == OFF_GFEAT);
  assign w_gfsel  = bus_wr & (a12 == OFF_GFSEL);
  assign w_iack   = bus_wr & (a12 == OFF_IACK);
  assign w_status = bus_wr & (a12 == OFF_STATUS);
  assign w_shmsel = bus_wr & (a12 == OFF_SHMSEL);
  assign zero_wr  = w_status & (bus_wdata == '0);

  // feature windows
  logic [31:0] dev_word;
  pvdev_featwin #(.NW(FEAT_WORDS)) u_feat (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clr      (zero_wr),
    .dev_feat (dev_feat_i),
    .dsel_we  (w_dfsel),
    .gsel_we  (w_gfsel),
    .gfeat_we (w_gfeat),
    .wdata    (bus_wdata),
    .dev_word (dev_word),
    .drv_feat (drv_feat_o)
  );

  // interrupt status
  logic [IRQ_W-1:0] irq_evt, irq_stat;
  always_comb begin
    irq_evt           = '0;
    irq_evt[IRQ_USED] = used_evt_i;
    irq_evt[IRQ_CFG]  = cfg_chg_i;
  end

  pvdev_irqstat u_irq (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .clr    (zero_wr),
    .evt    (irq_evt),
    .ack_we (w_iack),
    .ack    (bus_wdata[IRQ_W-1:0]),
    .stat   (irq_stat)
  );
  assign irq_o = |irq_stat;

  // configuration scratch and generation
  logic             cfg_hit;
  logic [31:0]      cfg_word;
  logic [GEN_W-1:0] cfg_gen;
  pvdev_cfgspace #(.WORDS(CFG_WORDS), .GEN_W(GEN_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_q_n),
    .addr  (a12),
    .wr_en (bus_wr),
    .wdata (bus_wdata),
    .chg   (cfg_chg_i),
    .hit   (cfg_hit),
    .rword (cfg_word),
    .gen   (cfg_gen)
  );

  // status byte, shared-memory selector, reset pulse, read data
  logic [7:0]  stat_q, stat_nxt;
  logic        stat_en;
  logic [31:0] shm_sel_q, shm_sel_nxt;
  logic        shm_sel_en;
  logic        rst_pulse_q;
  logic [31:0] rdata_q, rdata_nxt;
  logic        rdata_en;
  shm_desc_t   shm_cur;

  always_comb begin
    shm_cur.base = '1;
    shm_cur.len  = '1;
    for (int i = 0; i < NUM_SHM; i++) begin
      if (shm_sel_q == 32'(i)) begin
        shm_cur.len  = SHM_LEN;
        shm_cur.base = SHM_BASE + 64'(i) * SHM_LEN;
      end
    end
  end

  always_comb begin
    unique case (a12)
      OFF_MAGIC:     rdata_nxt = PV_MAGIC;
      OFF_VERSION:   rdata_nxt = PV_VERSION;
      OFF_DEVID:     rdata_nxt = DEV_ID;
      OFF_VENDOR:    rdata_nxt = VENDOR_ID;
      OFF_DFEAT:     rdata_nxt = dev_word;
      OFF_ISTAT:     rdata_nxt = 32'(irq_stat);
      OFF_STATUS:    rdata_nxt = {24'd0, stat_q};
      OFF_SHMSEL:    rdata_nxt = shm_sel_q;
      OFF_SHMLEN_L:  rdata_nxt = shm_cur.len[31:0];
      OFF_SHMLEN_H:  rdata_nxt = shm_cur.len[63:32];
      OFF_SHMBASE_L: rdata_nxt = shm_cur.base[31:0];
      OFF_SHMBASE_H: rdata_nxt = shm_cur.base[63:32];
      OFF_GEN:       rdata_nxt = 32'(cfg_gen);
      default:       rdata_nxt = cfg_hit ? cfg_word : '0;
    endcase
  end

  always_comb begin
    stat_en     = w_status;
    stat_nxt    = bus_wdata[7:0];
    shm_sel_en  = w_shmsel | zero_wr;
    shm_sel_nxt = zero_wr ? '0 : bus_wdata;
    rdata_en    = bus_rd;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stat_q      <= '0;
      shm_sel_q   <= '0;
      rst_pulse_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (stat_en)    stat_q    <= stat_nxt;
      if (shm_sel_en) shm_sel_q <= shm_sel_nxt;
      rst_pulse_q <= zero_wr;
      if (rdata_en)   rdata_q   <= rdata_nxt;
    end
  end

  assign status_o    = stat_q;
  assign dev_reset_o = rst_pulse_q;
  assign bus_rdata   = rdata_q;

  logic [FEAT_W-1:0] feat_unused_chk;
  assign feat_unused_chk = drv_feat_o;
endmodule

// File: rtl/pvdev_regfront_chk.sv
`timescale 1ns/1ps
module pvdev_regfront_chk
  import pvdev_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int FEAT_W = 64,
  parameter int GEN_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              used_evt_i,
  input logic              cfg_chg_i,
  input logic              irq_o,
  input logic [7:0]        status_o,
  input logic [FEAT_W-1:0] drv_feat_o,
  input logic              dev_reset_o,
  input logic [GEN_W-1:0]  gen
);
  logic zw;
  assign zw = bus_wr && (12'(bus_addr) == OFF_STATUS) && (bus_wdata == '0);

  p_reset_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zw |=> (dev_reset_o && !irq_o && status_o == 8'd0 && drv_feat_o == '0));

  p_reset_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_o |-> $past(zw));

  p_used_sets_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (used_evt_i && !zw) |=> irq_o);

  p_irq_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !bus_wr) |=> irq_o);

  p_gen_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg_i |=> (gen == $past(gen) + GEN_W'(1)));

  p_gen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_chg_i && !bus_wr) |=> $stable(gen));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  p_drvfeat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(drv_feat_o));

  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(status_o));
endmodule

bind pvdev_regfront pvdev_regfront_chk #(
  .ADDR_W (ADDR_W),
  .FEAT_W (FEAT_WORDS*32),
  .GEN_W  (GEN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .used_evt_i  (used_evt_i),
  .cfg_chg_i   (cfg_chg_i),
  .irq_o       (irq_o),
  .status_o    (status_o),
  .drv_feat_o  (drv_feat_o),
  .dev_reset_o (dev_reset_o),
  .gen         (cfg_gen)
);

// File: tb/pvdev_regfront_tb.sv
`timescale 1ns/1ps
module pvdev_regfront_tb;
  localparam logic [63:0] FEAT = 64'h0000_0013_3000_1ABC;
  localparam logic [63:0] SHM_BASE = 64'h0000_0040_0000_0000;
  localparam logic [63:0] SHM_LEN  = 64'h0000_0000_0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [63:0] dev_feat_i = FEAT;
  logic        used_evt_i = 1'b0, cfg_chg_i = 1'b0;
  logic        irq_o;
  logic [7:0]  status_o;
  logic [63:0] drv_feat_o;
  logic        dev_reset_o;

  always #2.5 clk = ~clk;

  pvdev_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dev_feat_i(dev_feat_i), .used_evt_i(used_evt_i), .cfg_chg_i(cfg_chg_i),
    .irq_o(irq_o), .status_o(status_o), .drv_feat_o(drv_feat_o),
    .dev_reset_o(dev_reset_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0]  m_st = '0;
  logic [1:0]  m_int = '0;
  logic [31:0] m_dsel = '0, m_gsel = '0, m_shm = '0, m_gen = '0, m_rdata = '0;
  logic [63:0] m_drv = '0;
  logic [31:0] m_cfg [4] = '{default: '0};
  logic        m_rst = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [11:0] a);
    logic [63:0] b, l;
    b = (m_shm == 0) ? SHM_BASE : '1;
    l = (m_shm == 0) ? SHM_LEN  : '1;
    case (a)
      12'h000: return 32'h7472_6976;
      12'h004: return 32'h2;
      12'h008: return 32'h1;
      12'h00C: return 32'h0000_5A17;
      12'h010: return (m_dsel == 0) ? FEAT[31:0] : (m_dsel == 1) ? FEAT[63:32] : 32'h0;
      12'h060: return {30'd0, m_int};
      12'h070: return {24'd0, m_st};
      12'h0AC: return m_shm;
      12'h0B0: return l[31:0];
      12'h0B4: return l[63:32];
      12'h0B8: return b[31:0];
      12'h0BC: return b[63:32];
      12'h0FC: return m_gen;
      12'h100: return m_cfg[0];
      12'h104: return m_cfg[1];
      12'h108: return m_cfg[2];
      12'h10C: return m_cfg[3];
      default: return 32'h0;
    endcase
  endfunction

  // one bus cycle with optional events; model advanced at the edge, all outputs compared after it
  task automatic step(input bit wr, input bit rd, input logic [11:0] a, input logic [31:0] d,
                      input bit ue, input bit ce, input string tag);
    logic [31:0] exp_rd;
    logic [1:0]  nint, ackm;
    bit          zw, cfgw;
    bus_wr = wr; bus_rd = rd; bus_addr = a[8:0]; bus_wdata = d;
    used_evt_i = ue; cfg_chg_i = ce;
    exp_rd = mread(a);
    zw   = wr && a == 12'h070 && d == 0;
    cfgw = wr && (a == 12'h100 || a == 12'h104 || a == 12'h108 || a == 12'h10C);
    ackm = (wr && a == 12'h064) ? d[1:0] : 2'b00;
    nint = zw ? 2'b00 : ((m_int & ~ackm) | {ce, ue});
    @(posedge clk);
    m_int = nint;
    m_rst = zw;
    if (ce || cfgw) m_gen = m_gen + 1;
    if (rd) m_rdata = exp_rd;
    if (wr) begin
      case (a)
        12'h014: m_dsel = d;
        12'h024: m_gsel = d;
        12'h020: if (m_gsel < 2) m_drv[m_gsel[0]*32 +: 32] = d;
        12'h070: m_st = d[7:0];
        12'h0AC: m_shm = d;
        12'h100: m_cfg[0] = d;
        12'h104: m_cfg[1] = d;
        12'h108: m_cfg[2] = d;
        12'h10C: m_cfg[3] = d;
        default: ;
      endcase
      if (zw) begin m_dsel = 0; m_gsel = 0; m_shm = 0; m_drv = 0; end
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; used_evt_i = 0; cfg_chg_i = 0;
    chk(irq_o == (|m_int), "R5 irq level", 64'(irq_o), 64'(|m_int));
    chk(status_o == m_st, "R6 status byte", 64'(status_o), 64'(m_st));
    chk(drv_feat_o == m_drv, "R3 driver features", drv_feat_o, m_drv);
    chk(dev_reset_o == m_rst, "R7 reset pulse", 64'(dev_reset_o), 64'(m_rst));
    chk(bus_rdata == m_rdata, rd ? tag : "R12 read data hold", 64'(bus_rdata), 64'(m_rdata));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1, 0, a, d, 0, 0, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    step(0, 1, a, 32'h0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(irq_o == 0 && status_o == 0, "R7 reset state irq/status", {irq_o, status_o}, 0);
    chk(bus_rdata == 0 && drv_feat_o == 0, "R9 reset state data", 64'(bus_rdata), 0);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 12'h0, 0, 0, 0, "R12 idle");

    rd(12'h000, "R1 magic");
    rd(12'h004, "R1 version");
    rd(12'h008, "R1 device id");
    rd(12'h00C, "R1 vendor id");

    rd(12'h010, "R2 feature word 0");
    wr(12'h014, 1, "R2 select 1");
    rd(12'h010, "R2 feature word 1");
    wr(12'h014, 2, "R2 select 2");
    rd(12'h010, "R2 feature out of range");

    wr(12'h020, 32'hDEAD_0001, "R3 write word 0");
    wr(12'h024, 1, "R3 select 1");
    wr(12'h020, 32'hBEEF_0002, "R3 write word 1");
    wr(12'h024, 5, "R3 select 5");
    wr(12'h020, 32'h1234_5678, "R3 ignored write");
    rd(12'h020, "R11 write-only reads zero");
    rd(12'h014, "R11 select reads zero");

    step(0, 0, 12'h0, 0, 1, 0, "R4 used event");
    rd(12'h060, "R4 status bit 0");
    step(0, 0, 12'h0, 0, 0, 1, "R8 config change");
    rd(12'h060, "R4 both bits");
    rd(12'h0FC, "R8 generation");
    wr(12'h064, 32'h1, "R4 ack bit 0");
    rd(12'h060, "R4 bit 1 remains");
    step(1, 0, 12'h064, 32'h2, 0, 1, "R4 ack and event same bit");
    rd(12'h060, "R4 bit 1 still set");
    wr(12'h064, 32'hFFFF_FFFC, "R4 ack undefined bits");
    wr(12'h060, 32'h0, "R11 write to read-only status");
    rd(12'h060, "R4 unchanged");
    wr(12'h064, 32'h3, "R4 ack all");
    rd(12'h060, "R5 idle after ack");

    wr(12'h100, 32'hA1A2_A3A4, "R9 scratch word 0");
    wr(12'h10C, 32'hB1B2_B3B4, "R9 scratch word 3");
    rd(12'h100, "R9 scratch read 0");
    rd(12'h10C, "R9 scratch read 3");
    step(1, 0, 12'h104, 32'h55, 0, 1, "R8 write and change together");
    rd(12'h0FC, "R8 generation single step");
    rd(12'h104, "R9 scratch read 1");

    rd(12'h0B0, "R10 length low");
    rd(12'h0BC, "R10 base high");
    wr(12'h0AC, 3, "R10 select absent");
    rd(12'h0AC, "R10 selector readback");
    rd(12'h0B4, "R10 absent length");
    rd(12'h0B8, "R10 absent base");

    rd(12'h050, "R11 unmapped");
    rd(12'h002, "R11 misaligned");
    wr(12'h000, 32'h0, "R11 read-only write");
    rd(12'h000, "R11 magic intact");
    wr(12'h102, 32'hFFFF_FFFF, "R11 misaligned write");
    rd(12'h100, "R11 scratch intact");

    wr(12'h070, 32'h0F, "R6 status write");
    rd(12'h070, "R6 status read");
    step(0, 0, 12'h0, 0, 1, 0, "R4 used event");
    step(1, 0, 12'h070, 32'h0, 1, 0, "R7 zero write with event");
    rd(12'h060, "R7 interrupt cleared");
    rd(12'h010, "R7 selector cleared");
    rd(12'h0AC, "R7 shm selector cleared");
    rd(12'h0FC, "R8 generation kept");
    repeat (3) step(0, 0, 12'h0, 0, 0, 0, "R12 idle");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule